// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences a small processor core into and out of two sleep levels: a deep halt that can only be left through a reset, and a lighter doze that keeps all state and resumes at the next instruction. Firmware arms a sleep level by writing a request bit through a register write port. The controller then waits for the writing instruction to retire before it gates the core clock and the internal oscillator. While asleep it watches the wake inputs through two-flop synchronizers. These inputs are a port-match event, a comparator output and an external reset. On exit it tells the core either to continue with a one-cycle resume pulse and a wake-source code, or to take the reset path.

The block runs on an always-on clock that is never gated. A missing-clock watchdog counts always-on cycles while the core clock is gated. When it is enabled and the count reaches its timeout, it raises an internal reset and holds it for a set number of cycles. The external-oscillator enable passes straight through and is never touched by the sequencer.

States: ACTIVE, ARM_STOP, ARM_SUSP, STOP, SUSPEND, WAKE, RESET. Transitions:
- ACTIVE to ARM_STOP on a halt-request write.
- ACTIVE to ARM_SUSP on a doze-request write.
- ARM_STOP to STOP on retire.
- ARM_SUSP to SUSPEND on retire.
- SUSPEND to WAKE on a wake event.
- WAKE to ACTIVE after one cycle.
- Any state to RESET on a synchronized external reset or a watchdog reset.
- RESET to ACTIVE once both reset sources are low.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After `rst_n` is released the controller is in ACTIVE. `core_clk_en`, `iosc_en` and `pm_clk_en` are 1. `core_rst`, `resume`, `wake_src`, `stop_flag`, `susp_flag` and `mcd_rst` are 0.
- R2: A write with `wr_pwr`=1 and `wr_data` bit 1 set moves the controller to ARM_STOP, so `stop_flag` reads 1 while the clocks stay on. The cycle after the first `retire` seen in ARM_STOP, it is in STOP with `core_clk_en`, `iosc_en` and `pm_clk_en` all 0.
- R3: A write with `wr_osc`=1 and `wr_data` bit 5 set moves the controller to ARM_SUSP, so `susp_flag` reads 1. The cycle after the next `retire`, it is in SUSPEND with `core_clk_en`=0, `iosc_en`=0 and `pm_clk_en`=1.
- R4: If both strobes arrive in one cycle with both bits set, the halt request wins: `stop_flag`=1 and `susp_flag`=0.
- R5: `xosc_en` equals `xosc_en_req` in every state.
- R6: In STOP, port-match and comparator activity have no effect. The controller stays in STOP and never pulses `resume`.
- R7: In SUSPEND, a high `port_match` raises `resume` for one cycle three cycles after it is applied, with `wake_src`=2'b01. The controller then returns to ACTIVE with `susp_flag` cleared and the clocks on.
- R8: In SUSPEND, a low `cmp_out` wakes the core only while `cmp_wake_en`=1. The wake pulses `resume` with `wake_src`=2'b10. While `cmp_wake_en`=0 the controller stays asleep.
- R9: A high `ext_rst` moves any state to RESET three cycles after it is applied. There, `core_rst`=1, the clocks are on and both flags are cleared. RESET returns to ACTIVE three cycles after `ext_rst` falls, without a `resume` pulse.
- R10: With `mcd_en`=1 and the core clock gated for `MCD_TIMEOUT` consecutive cycles, `mcd_rst` goes high for `MCD_HOLD` cycles and `core_rst` follows one cycle later. With `mcd_en`=0 the controller stays in STOP indefinitely.
- R11: A write without the relevant request bit set, or any write outside ACTIVE, does not change either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_pwr | input | 1 | Write strobe, power-control register (halt request at bit 1) |
| wr_osc | input | 1 | Write strobe, oscillator-control register (doze request at bit 5) |
| wr_data | input | DATA_W | Write data |
| retire | input | 1 | Instruction-retire strobe from the core |
| port_match | input | 1 | Port-match wake event, asynchronous |
| cmp_out | input | 1 | Comparator output, asynchronous; low requests wake |
| cmp_wake_en | input | 1 | Enables the comparator as a wake source |
| ext_rst | input | 1 | External reset request, asynchronous, active high |
| mcd_en | input | 1 | Missing-clock watchdog enable |
| xosc_en_req | input | 1 | External-oscillator enable from configuration |
| core_clk_en | output | 1 | Core and digital-peripheral clock gate enable |
| iosc_en | output | 1 | High-frequency internal oscillator enable |
| pm_clk_en | output | 1 | Port-match logic clock enable |
| xosc_en | output | 1 | External-oscillator enable |
| core_rst | output | 1 | Core takes the reset path |
| resume | output | 1 | One-cycle pulse: continue at the next instruction |
| wake_src | output | 2 | Wake source during `resume`: bit 0 port match, bit 1 comparator |
| stop_flag | output | 1 | Halt request bit read-back |
| susp_flag | output | 1 | Doze request bit read-back |
| mcd_rst | output | 1 | Missing-clock watchdog reset |

## Verification
The hardest situation to reach is the watchdog reset out of STOP. It needs the core clock to stay gated for the full timeout while nothing else ends the state. To get there, the bench enters STOP with the watchdog disabled and holds it past the timeout to show nothing happens. It then enables the watchdog mid-sleep and counts cycles to the rise of `mcd_rst` and then `core_rst`. The priority case, where the halt and doze strobes arrive together, is driven directly, followed by a doze write while armed for halt to show it is ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        LP_ACTIVE   = 3'd0,
        LP_ARM_STOP = 3'd1,
        LP_ARM_SUSP = 3'd2,
        LP_STOP     = 3'd3,
        LP_SUSPEND  = 3'd4,
        LP_WAKE     = 3'd5,
        LP_RESET    = 3'd6
    } lp_state_e;

    localparam int HALT_REQ_BIT = 1;
    localparam int DOZE_REQ_BIT = 5;
    localparam int N_WAKE_IN    = 3;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic stage1_q;
        logic stage2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= async_in[g];
                stage2_q <= stage1_q;
            end
        end
        assign sync_out[g] = stage2_q;
    end
endmodule

// File: rtl/lpm_mcd.sv
module lpm_mcd #(
    parameter int TIMEOUT = 100,
    parameter int HOLD    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic gated,
    output logic mcd_rst
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam int HW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            cnt_q  <= '0;
        end else if (en && gated) begin
            if (cnt_q == CW'(TIMEOUT - 1)) begin
                hold_q <= HW'(HOLD);
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign mcd_rst = (hold_q != '0);

    assert_mcd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcd_rst) |-> $past(en && gated));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pwr,
    input  logic              wr_osc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              retire,
    input  logic              pm_s,
    input  logic              cmp_s,
    input  logic              cmp_wake_en,
    input  logic              rst_req,
    output logic              core_clk_en,
    output logic              iosc_en,
    output logic              pm_clk_en,
    output logic              core_rst,
    output logic              resume,
    output logic [1:0]        wake_src,
    output logic              stop_flag,
    output logic              susp_flag
);
    localparam logic [DATA_W-1:0] REQ_MASK =
        (DATA_W'(1) << HALT_REQ_BIT) | (DATA_W'(1) << DOZE_REQ_BIT);

    lp_state_e state_q, state_d;
    logic [1:0] src_q, src_d;
    logic       halt_wr, doze_wr, cmp_wake;
    logic       unused_wr;

    assign halt_wr   = wr_pwr && wr_data[HALT_REQ_BIT];
    assign doze_wr   = wr_osc && wr_data[DOZE_REQ_BIT];
    assign cmp_wake  = cmp_wake_en && !cmp_s;
    assign unused_wr = ^(wr_data & ~REQ_MASK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LP_ACTIVE;
            src_q   <= 2'b00;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        if (rst_req) begin
            state_d = LP_RESET;
        end else begin
            unique case (state_q)
                LP_ACTIVE: begin
                    if (halt_wr)      state_d = LP_ARM_STOP;
                    else if (doze_wr) state_d = LP_ARM_SUSP;
                end
                LP_ARM_STOP: if (retire) state_d = LP_STOP;
                LP_ARM_SUSP: if (retire) state_d = LP_SUSPEND;
                LP_STOP:     state_d = LP_STOP;
                LP_SUSPEND: begin
                    if (pm_s || cmp_wake) begin
                        state_d = LP_WAKE;
                        src_d   = {cmp_wake, pm_s};
                    end
                end
                LP_WAKE:     state_d = LP_ACTIVE;
                LP_RESET:    state_d = LP_ACTIVE;
                default:     state_d = LP_ACTIVE;
            endcase
        end
    end

    // outputs
    always_comb begin
        core_clk_en = 1'b1;
        iosc_en     = 1'b1;
        pm_clk_en   = 1'b1;
        core_rst    = 1'b0;
        resume      = 1'b0;
        wake_src    = 2'b00;
        stop_flag   = 1'b0;
        susp_flag   = 1'b0;
        unique case (state_q)
            LP_ACTIVE:   ;
            LP_ARM_STOP: stop_flag = 1'b1;
            LP_ARM_SUSP: susp_flag = 1'b1;
            LP_STOP: begin
                stop_flag   = 1'b1;
                core_clk_en = 1'b0;
                iosc_en     = 1'b0;
                pm_clk_en   = 1'b0;
            end
            LP_SUSPEND: begin
                susp_flag   = 1'b1;
                core_clk_en = 1'b0;
                iosc_en     = 1'b0;
            end
            LP_WAKE: begin
                resume   = 1'b1;
                wake_src = src_q;
            end
            LP_RESET:    core_rst = 1'b1;
            default:     ;
        endcase
    end

    assert_halt_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_STOP) |=> (state_q == LP_STOP || state_q == LP_RESET));

    assert_gate_on_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> $past(retire));

    assert_resume_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (wake_src != 2'b00));

    assert_resume_from_doze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> $past(susp_flag && !core_clk_en));
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int MCD_TIMEOUT = 100,
    parameter int MCD_HOLD    = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pwr,
    input  logic              wr_osc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              retire,
    input  logic              port_match,
    input  logic              cmp_out,
    input  logic              cmp_wake_en,
    input  logic              ext_rst,
    input  logic              mcd_en,
    input  logic              xosc_en_req,
    output logic              core_clk_en,
    output logic              iosc_en,
    output logic              pm_clk_en,
    output logic              xosc_en,
    output logic              core_rst,
    output logic              resume,
    output logic [1:0]        wake_src,
    output logic              stop_flag,
    output logic              susp_flag,
    output logic              mcd_rst
);
    logic [N_WAKE_IN-1:0] wake_sync;
    logic                 pm_s, cmp_s, xrst_s;

    lpm_sync #(.WIDTH(N_WAKE_IN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ext_rst, cmp_out, port_match}),
        .sync_out (wake_sync)
    );
    assign pm_s   = wake_sync[0];
    assign cmp_s  = wake_sync[1];
    assign xrst_s = wake_sync[2];

    lpm_mcd #(.TIMEOUT(MCD_TIMEOUT), .HOLD(MCD_HOLD)) u_mcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mcd_en),
        .gated   (!core_clk_en),
        .mcd_rst (mcd_rst)
    );

    lpm_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_pwr      (wr_pwr),
        .wr_osc      (wr_osc),
        .wr_data     (wr_data),
        .retire      (retire),
        .pm_s        (pm_s),
        .cmp_s       (cmp_s),
        .cmp_wake_en (cmp_wake_en),
        .rst_req     (xrst_s || mcd_rst),
        .core_clk_en (core_clk_en),
        .iosc_en     (iosc_en),
        .pm_clk_en   (pm_clk_en),
        .core_rst    (core_rst),
        .resume      (resume),
        .wake_src    (wake_src),
        .stop_flag   (stop_flag),
        .susp_flag   (susp_flag)
    );

    assign xosc_en = xosc_en_req;

    assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(xrst_s || mcd_rst));
endmodule

// File: tb/tb_lpm_seq_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_seq_ctrl;
    localparam int TO   = 100;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_pwr = 0, wr_osc = 0, retire = 0, port_match = 0, cmp_out = 1;
    logic cmp_wake_en = 0, ext_rst = 0, mcd_en = 0, xosc_en_req = 0;
    logic [7:0] wr_data = 8'h00;
    logic core_clk_en, iosc_en, pm_clk_en, xosc_en, core_rst, resume;
    logic stop_flag, susp_flag, mcd_rst;
    logic [1:0] wake_src;

    always #2 clk = ~clk;

    lpm_seq_ctrl #(.MCD_TIMEOUT(TO), .MCD_HOLD(HOLD), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_pwr(wr_pwr), .wr_osc(wr_osc),
        .wr_data(wr_data), .retire(retire), .port_match(port_match),
        .cmp_out(cmp_out), .cmp_wake_en(cmp_wake_en), .ext_rst(ext_rst),
        .mcd_en(mcd_en), .xosc_en_req(xosc_en_req), .core_clk_en(core_clk_en),
        .iosc_en(iosc_en), .pm_clk_en(pm_clk_en), .xosc_en(xosc_en),
        .core_rst(core_rst), .resume(resume), .wake_src(wake_src),
        .stop_flag(stop_flag), .susp_flag(susp_flag), .mcd_rst(mcd_rst)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model: 0 active,1 armed halt,2 armed doze,3 halt,4 doze,5 wake,6 reset
    int m_st = 0;
    int m_cnt = 0;
    int m_hold = 0;
    bit [1:0] m_src = 0;
    bit p1 = 0, p2 = 0, c1 = 0, c2 = 0, x1 = 0, x2 = 0;

    always @(posedge clk) begin : model
        int ns;
        bit [1:0] nsrc;
        bit asleep, cw;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_hold = 0; m_src = 0;
            p1 = 0; p2 = 0; c1 = 0; c2 = 0; x1 = 0; x2 = 0;
        end else begin
            ns = m_st; nsrc = m_src;
            asleep = (m_st == 3 || m_st == 4);
            cw = cmp_wake_en && !c2;
            if (x2 || m_hold != 0) ns = 6;
            else if (m_st == 0 && wr_pwr && wr_data[1]) ns = 1;
            else if (m_st == 0 && wr_osc && wr_data[5]) ns = 2;
            else if (m_st == 1 && retire) ns = 3;
            else if (m_st == 2 && retire) ns = 4;
            else if (m_st == 4 && (p2 || cw)) begin ns = 5; nsrc = {cw, p2}; end
            else if (m_st == 5 || m_st == 6) ns = 0;
            if (m_hold != 0) begin m_hold--; m_cnt = 0; end
            else if (mcd_en && asleep) begin
                if (m_cnt == TO - 1) begin m_hold = HOLD; m_cnt = 0; end
                else m_cnt++;
            end else m_cnt = 0;
            p2 = p1; p1 = port_match;
            c2 = c1; c1 = cmp_out;
            x2 = x1; x1 = ext_rst;
            m_st = ns; m_src = nsrc;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "core_clk_en", core_clk_en, !(m_st == 3 || m_st == 4));
            chk("R3", "iosc_en", iosc_en, !(m_st == 3 || m_st == 4));
            chk("R3", "pm_clk_en", pm_clk_en, m_st != 3);
            chk("R5", "xosc_en", xosc_en, xosc_en_req);
            chk("R9", "core_rst", core_rst, m_st == 6);
            chk("R7", "resume", resume, m_st == 5);
            chk("R8", "wake_src", wake_src, (m_st == 5) ? m_src : 0);
            chk("R2", "stop_flag", stop_flag, m_st == 1 || m_st == 3);
            chk("R3", "susp_flag", susp_flag, m_st == 2 || m_st == 4);
            chk("R10", "mcd_rst", mcd_rst, m_hold != 0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1", "core_clk_en", core_clk_en, 1);
        chk("R1", "core_rst", core_rst, 0);
        chk("R1", "flags", {stop_flag, susp_flag}, 0);
        chk("R1", "resume", resume, 0);
        chk("R1", "mcd_rst", mcd_rst, 0);

        // R11 writes without request bits
        wr_pwr = 1; wr_data = 8'hFD; cyc(1); wr_pwr = 0;
        chk("R11", "stop_flag after write without bit", stop_flag, 0);
        wr_osc = 1; wr_data = 8'hDF; cyc(1); wr_osc = 0;
        chk("R11", "susp_flag after write without bit", susp_flag, 0);

        // R2 halt entry waits for retire; R5 pass-through
        xosc_en_req = 1;
        wr_pwr = 1; wr_data = 8'h02; cyc(1); wr_pwr = 0;
        chk("R2", "armed stop_flag", stop_flag, 1);
        cyc(2);
        chk("R2", "clock on before retire", core_clk_en, 1);
        retire = 1; cyc(1); retire = 0;
        chk("R2", "halted core_clk_en", core_clk_en, 0);
        chk("R2", "halted pm_clk_en", pm_clk_en, 0);
        chk("R5", "xosc_en in halt", xosc_en, 1);
        xosc_en_req = 0; cyc(1);
        chk("R5", "xosc_en follows", xosc_en, 0);

        // R6 wake inputs ignored in halt
        port_match = 1; cmp_wake_en = 1; cmp_out = 0;
        cyc(6);
        chk("R6", "still halted", core_clk_en, 0);
        chk("R6", "no resume", resume, 0);
        port_match = 0; cmp_out = 1; cmp_wake_en = 0;

        // R10 watchdog disabled: halt persists
        cyc(TO + 10);
        chk("R10", "halt persists with watchdog off", stop_flag, 1);

        // R9 external reset
        ext_rst = 1; cyc(3);
        chk("R9", "core_rst", core_rst, 1);
        chk("R9", "flags cleared", {stop_flag, susp_flag}, 0);
        chk("R9", "clock on in reset", core_clk_en, 1);
        ext_rst = 0; cyc(3);
        chk("R9", "reset released", core_rst, 0);
        chk("R9", "no resume after reset", resume, 0);

        // R3 doze entry
        wr_osc = 1; wr_data = 8'h20; cyc(1); wr_osc = 0;
        chk("R3", "armed susp_flag", susp_flag, 1);
        retire = 1; cyc(1); retire = 0;
        chk("R3", "doze core_clk_en", core_clk_en, 0);
        chk("R3", "doze iosc_en", iosc_en, 0);
        chk("R3", "doze pm_clk_en", pm_clk_en, 1);

        // R7 port-match wake
        port_match = 1; cyc(2);
        chk("R7", "not yet resumed", resume, 0);
        cyc(1);
        chk("R7", "resume", resume, 1);
        chk("R7", "wake_src", wake_src, 1);
        port_match = 0; cyc(1);
        chk("R7", "resume one cycle", resume, 0);
        chk("R7", "susp_flag cleared", susp_flag, 0);
        chk("R7", "clock on", core_clk_en, 1);

        // R8 comparator wake gated by enable
        wr_osc = 1; wr_data = 8'h20; cyc(1); wr_osc = 0;
        retire = 1; cyc(1); retire = 0;
        cmp_out = 0; cyc(6);
        chk("R8", "disabled comparator ignored", susp_flag, 1);
        cmp_wake_en = 1; cyc(1);
        chk("R8", "resume", resume, 1);
        chk("R8", "wake_src", wake_src, 2);
        cmp_wake_en = 0; cmp_out = 1; cyc(3);

        // R4 halt wins; R11 write while armed ignored
        wr_pwr = 1; wr_osc = 1; wr_data = 8'h22; cyc(1); wr_pwr = 0; wr_osc = 0;
        chk("R4", "stop_flag", stop_flag, 1);
        chk("R4", "susp_flag", susp_flag, 0);
        wr_osc = 1; wr_data = 8'h20; cyc(1); wr_osc = 0;
        chk("R11", "doze write while armed", susp_flag, 0);
        retire = 1; cyc(1); retire = 0;
        chk("R4", "halted", core_clk_en, 0);

        // R10 watchdog reset from halt
        mcd_en = 1; cyc(TO);
        chk("R10", "mcd_rst raised", mcd_rst, 1);
        chk("R10", "core_rst not yet", core_rst, 0);
        cyc(1);
        chk("R10", "core_rst follows", core_rst, 1);
        cyc(HOLD);
        chk("R10", "mcd_rst released", mcd_rst, 0);
        chk("R10", "back to active", core_rst, 0);
        chk("R10", "halt cleared", stop_flag, 0);
        mcd_en = 0;
        cyc(2);
        summary();
    end
endmodule